// File: doc/BRIEF.md
# External Clock Stuck Monitor

This block watches the external fast crystal oscillator from the domain of the always-running internal fast RC oscillator. It reports the external clock as failed when that clock stops toggling, whether it is held low or held high. The external clock is sampled through a synchronizer, and every transition it shows restarts a count of reference cycles. If the count reaches a set limit with no transition, the block declares a failure.

A failure has several effects. The block turns off the external oscillator enable. It also shuts down the PLL when the PLL runs from the external oscillator and the PLL output drives the system clock. It sets a sticky stuck flag, which in turn forces the system clock selector back to the internal RC. When the interrupt enable is set, it raises a request on the non-maskable interrupt line. While the monitor is enabled, the block holds the internal RC on, because that RC is its reference clock.

Software sets the monitor enable after the external oscillator has started up, and clears it before stopping that oscillator. After a failure, software clears the flag by writing 1 to it. It then writes the oscillator enable again to restart the external oscillator.

Top module: `ext_clk_stuck_mon`

## Requirements
- R1: After reset, `osc_en`, `stuck_flag`, `nmi_req`, `force_rc_sel` and `pll_kill` are all 0.
- R2: While `mon_en` is 1 and `ext_clk` keeps toggling at least once every few reference cycles, `stuck_flag` stays 0.
- R3: With `mon_en` at 1, if `ext_clk` stays low, `stuck_flag` rises no earlier than STUCK_LIMIT-1 and no later than STUCK_LIMIT+6 reference cycles after the last transition.
- R4: With `mon_en` at 1, if `ext_clk` stays high, `stuck_flag` rises within the same window as in R3.
- R5: While `mon_en` is 0, no failure is ever declared, however long `ext_clk` stays still.
- R6: Setting `osc_en_wr` with `osc_en_wdata` loads `osc_en` one cycle later. A failure forces `osc_en` to 0. While `stuck_flag` is 1, writes to the oscillator enable are ignored, so `osc_en` stays 0 until the flag is cleared and a new write is made.
- R7: `stuck_flag` is sticky. Only a cycle with `flag_clr` at 1 clears it, one cycle later.
- R8: `nmi_req` is 1 exactly when `stuck_flag` and `irq_en` are both 1.
- R9: `force_rc_sel` is 1 while `stuck_flag` is 1, which requests the internal RC as the system clock.
- R10: At a failure, `pll_kill` is set only if `pll_src_ext` and `pll_is_sys` are both 1. The same flag clear that clears `stuck_flag` also clears `pll_kill`.
- R11: `rc_force_on` is 1 whenever `mon_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock from the internal fast RC |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_clk | input | 1 | Monitored external oscillator clock, asynchronous |
| mon_en | input | 1 | Monitor enable |
| irq_en | input | 1 | Failure interrupt enable |
| flag_clr | input | 1 | Write-1-to-clear strobe for the stuck flag |
| osc_en_wr | input | 1 | Write strobe for the external oscillator enable |
| osc_en_wdata | input | 1 | Value written to the external oscillator enable |
| pll_src_ext | input | 1 | PLL takes the external oscillator as its input |
| pll_is_sys | input | 1 | PLL output is the current system clock |
| osc_en | output | 1 | Effective external oscillator enable |
| pll_kill | output | 1 | Forces the PLL off after a failure |
| stuck_flag | output | 1 | Sticky failure flag |
| nmi_req | output | 1 | Non-maskable interrupt request |
| force_rc_sel | output | 1 | Forces the system clock selector to the internal RC |
| rc_force_on | output | 1 | Keeps the internal RC running |

## Verification
The bench stops the external clock once at each level and samples the flag just before and just after the detection window. A design whose counter is off by a large amount, or that only catches one of the two levels, would flag too early or never. It tries an oscillator-enable write while the flag is set, which a design without the write lock would accept and so restart a failed oscillator. It triggers failures with and without the PLL on the external source, which exposes a design that kills the PLL unconditionally. It also leaves the clock stopped with the monitor disabled, where a design that ignores the enable would flag falsely.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  localparam int unsigned DEF_STUCK_LIMIT = 32;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/clkmon_rst_sync.sv
module clkmon_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] rst_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) rst_q <= 2'b00;
    else           rst_q <= {rst_q[0], 1'b1};
  end

  assign rst_n_out = rst_q[1];
endmodule

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
  parameter int unsigned STAGES = clkmon_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_seen
);
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d[0] = async_in;
  end

  genvar g;
  generate
    for (g = 1; g <= STAGES; g++) begin : g_stage
      always_comb chain_d[g] = chain_q[g-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  // compare the last synchronized stage against the one before it
  assign edge_seen = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/clkmon_idle_cnt.sv
module clkmon_idle_cnt #(
  parameter int unsigned STUCK_LIMIT = clkmon_pkg::DEF_STUCK_LIMIT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic edge_seen,
  output logic fail
);
  localparam int unsigned CW = clkmon_pkg::cnt_width(STUCK_LIMIT);
  localparam logic [CW-1:0] LAST = CW'(STUCK_LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_ce;
  logic          restart;

  always_comb begin
    fail    = enable && !edge_seen && (cnt_q == LAST);
    restart = !enable || edge_seen || fail;
    cnt_ce  = restart || (cnt_q != LAST);
    cnt_d   = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clkmon_ctrl.sv
module clkmon_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic fail,
  input  logic flag_clr,
  input  logic osc_en_wr,
  input  logic osc_en_wdata,
  input  logic pll_src_ext,
  input  logic pll_is_sys,
  output logic osc_en,
  output logic stuck_flag,
  output logic pll_kill
);
  logic osc_q, osc_d, osc_ce;
  logic flag_q, flag_d, flag_ce;
  logic kill_q, kill_d, kill_ce;

  always_comb begin
    // failure wins over a clear in the same cycle
    flag_ce = fail || flag_clr;
    flag_d  = fail;

    kill_ce = fail || flag_clr;
    kill_d  = fail ? (kill_q || (pll_src_ext && pll_is_sys)) : 1'b0;

    // oscillator enable writes are locked out while the flag stands
    osc_ce  = fail || (osc_en_wr && !flag_q);
    osc_d   = fail ? 1'b0 : osc_en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q  <= 1'b0;
      flag_q <= 1'b0;
      kill_q <= 1'b0;
    end else begin
      if (osc_ce)  osc_q  <= osc_d;
      if (flag_ce) flag_q <= flag_d;
      if (kill_ce) kill_q <= kill_d;
    end
  end

  assign osc_en     = osc_q;
  assign stuck_flag = flag_q;
  assign pll_kill   = kill_q;
endmodule

// File: rtl/ext_clk_stuck_mon.sv
module ext_clk_stuck_mon #(
  parameter int unsigned STUCK_LIMIT = clkmon_pkg::DEF_STUCK_LIMIT,
  parameter int unsigned SYNC_STAGES = clkmon_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic mon_en,
  input  logic irq_en,
  input  logic flag_clr,
  input  logic osc_en_wr,
  input  logic osc_en_wdata,
  input  logic pll_src_ext,
  input  logic pll_is_sys,
  output logic osc_en,
  output logic pll_kill,
  output logic stuck_flag,
  output logic nmi_req,
  output logic force_rc_sel,
  output logic rc_force_on
);
  logic rst_n_s;
  logic edge_seen;
  logic fail;

  clkmon_rst_sync u_rst (
    .clk       (clk_ref),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  clkmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk_ref),
    .rst_n     (rst_n_s),
    .async_in  (ext_clk),
    .edge_seen (edge_seen)
  );

  clkmon_idle_cnt #(.STUCK_LIMIT(STUCK_LIMIT)) u_cnt (
    .clk       (clk_ref),
    .rst_n     (rst_n_s),
    .enable    (mon_en),
    .edge_seen (edge_seen),
    .fail      (fail)
  );

  clkmon_ctrl u_ctrl (
    .clk          (clk_ref),
    .rst_n        (rst_n_s),
    .fail         (fail),
    .flag_clr     (flag_clr),
    .osc_en_wr    (osc_en_wr),
    .osc_en_wdata (osc_en_wdata),
    .pll_src_ext  (pll_src_ext),
    .pll_is_sys   (pll_is_sys),
    .osc_en       (osc_en),
    .stuck_flag   (stuck_flag),
    .pll_kill     (pll_kill)
  );

  assign nmi_req      = stuck_flag && irq_en;
  assign force_rc_sel = stuck_flag;
  assign rc_force_on  = mon_en;
endmodule

// File: rtl/ext_clk_stuck_mon_chk.sv
module ext_clk_stuck_mon_chk (
  input logic clk_ref,
  input logic rst_n,
  input logic mon_en,
  input logic flag_clr,
  input logic osc_en,
  input logic pll_kill,
  input logic stuck_flag,
  input logic nmi_req,
  input logic force_rc_sel,
  input logic rc_force_on
);
  p_no_fail_disabled_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!mon_en && !stuck_flag) |=> !stuck_flag);

  p_osc_locked_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !(osc_en && stuck_flag));

  p_flag_sticky_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (stuck_flag && !flag_clr) |=> stuck_flag);

  p_nmi_needs_flag_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    nmi_req |-> stuck_flag);

  p_fallback_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(stuck_flag) |-> force_rc_sel);

  p_pll_kill_with_flag_r10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pll_kill |-> stuck_flag);

  p_rc_on_r11: assert property (@(posedge clk_ref) disable iff (!rst_n)
    mon_en |-> rc_force_on);
endmodule

bind ext_clk_stuck_mon ext_clk_stuck_mon_chk chk_i (
  .clk_ref      (clk_ref),
  .rst_n        (rst_n),
  .mon_en       (mon_en),
  .flag_clr     (flag_clr),
  .osc_en       (osc_en),
  .pll_kill     (pll_kill),
  .stuck_flag   (stuck_flag),
  .nmi_req      (nmi_req),
  .force_rc_sel (force_rc_sel),
  .rc_force_on  (rc_force_on)
);

// File: tb/ext_clk_stuck_mon_tb_top.sv
`timescale 1ns/1ps
module ext_clk_stuck_mon_tb_top;
  localparam int LIMIT = 32;

  logic clk_ref = 1'b0;
  logic rst_n;
  logic ext_clk = 1'b0;
  logic ext_run = 1'b0;
  logic mon_en, irq_en, flag_clr, osc_en_wr, osc_en_wdata, pll_src_ext, pll_is_sys;
  logic osc_en, pll_kill, stuck_flag, nmi_req, force_rc_sel, rc_force_on;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  // bit order: {rc_force_on, force_rc_sel, pll_kill, nmi_req, stuck_flag, osc_en}
  typedef struct {
    string      req;
    logic [5:0] exp;
    logic [5:0] mask;
  } exp_t;
  exp_t sb_q[$];

  ext_clk_stuck_mon #(.STUCK_LIMIT(LIMIT)) dut_i (
    .clk_ref(clk_ref), .rst_n(rst_n), .ext_clk(ext_clk), .mon_en(mon_en),
    .irq_en(irq_en), .flag_clr(flag_clr), .osc_en_wr(osc_en_wr),
    .osc_en_wdata(osc_en_wdata), .pll_src_ext(pll_src_ext), .pll_is_sys(pll_is_sys),
    .osc_en(osc_en), .pll_kill(pll_kill), .stuck_flag(stuck_flag), .nmi_req(nmi_req),
    .force_rc_sel(force_rc_sel), .rc_force_on(rc_force_on)
  );

  always #5 clk_ref = ~clk_ref;

  initial begin
    forever begin
      #7;
      if (ext_run) ext_clk = ~ext_clk;
    end
  end

  // monitor: compare queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk_ref);
      while (sb_q.size() > 0) begin
        exp_t e;
        logic [5:0] act;
        e   = sb_q.pop_front();
        act = {rc_force_on, force_rc_sel, pll_kill, nmi_req, stuck_flag, osc_en};
        n_cmp++;
        if ((act & e.mask) !== (e.exp & e.mask)) begin
          n_bad++;
          $display("FAIL %s: actual=%b expected=%b mask=%b", e.req, act, e.exp, e.mask);
        end
      end
    end
  end

  task automatic push(input string req, input logic [5:0] exp, input logic [5:0] mask);
    exp_t e;
    e.req = req; e.exp = exp; e.mask = mask;
    sb_q.push_back(e);
    @(negedge clk_ref);
    #1;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_ref);
    #1;
  endtask

  task automatic write_osc(input logic v);
    osc_en_wr = 1'b1; osc_en_wdata = v;
    tick(1);
    osc_en_wr = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk_ref);
      cyc++;
      if (cyc > 100000 && !done) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
      end
    end
  end

  initial begin
    rst_n = 1'b0; mon_en = 0; irq_en = 0; flag_clr = 0; osc_en_wr = 0;
    osc_en_wdata = 0; pll_src_ext = 0; pll_is_sys = 0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    push("R1 reset state", 6'b000000, 6'b111111);

    write_osc(1'b1);
    push("R6 oscillator enable write", 6'b000001, 6'b000001);

    // R2: running clock, monitor on
    ext_run = 1'b1; mon_en = 1'b1;
    tick(200);
    push("R2 no false failure", 6'b000001, 6'b001111);
    push("R11 rc forced on", 6'b100000, 6'b100000);

    // R3: stop low with PLL on external source as system clock
    pll_src_ext = 1; pll_is_sys = 1; irq_en = 0;
    ext_run = 1'b0; ext_clk = 1'b0;
    tick(LIMIT - 2);
    push("R3 no early flag (low)", 6'b000000, 6'b000010);
    tick(8);
    push("R3 flag after stuck low", 6'b000010, 6'b000010);
    push("R6 oscillator forced off", 6'b000000, 6'b000001);
    push("R8 nmi masked", 6'b000000, 6'b000100);
    push("R9 fallback to rc", 6'b010000, 6'b010000);
    push("R10 pll killed", 6'b001000, 6'b001000);
    irq_en = 1; #1;
    push("R8 nmi raised", 6'b000100, 6'b000100);

    // R7: sticky, R6: write locked
    mon_en = 0;
    tick(10);
    push("R7 flag sticky", 6'b000010, 6'b000010);
    write_osc(1'b1);
    push("R6 write ignored while flagged", 6'b000000, 6'b000001);

    clear_flag();
    push("R7 flag cleared", 6'b000000, 6'b000010);
    push("R10 pll kill cleared", 6'b000000, 6'b001000);
    push("R9 fallback released", 6'b000000, 6'b010000);
    push("R8 nmi dropped", 6'b000000, 6'b000100);
    push("R6 oscillator stays off", 6'b000000, 6'b000001);
    write_osc(1'b1);
    push("R6 rewrite restores oscillator", 6'b000001, 6'b000001);

    // R5: stopped high with monitor disabled
    ext_clk = 1'b1;
    tick(3 * LIMIT);
    push("R5 no detection when disabled", 6'b000001, 6'b000011);

    // R4: stuck high, PLL not on external source
    pll_src_ext = 0;
    ext_run = 1'b1;
    tick(20);
    mon_en = 1;
    tick(20);
    ext_run = 1'b0; ext_clk = 1'b1;
    tick(LIMIT - 2);
    push("R4 no early flag (high)", 6'b000000, 6'b000010);
    tick(8);
    push("R4 flag after stuck high", 6'b000010, 6'b000011);
    push("R10 pll untouched", 6'b000000, 6'b001000);

    mon_en = 0;
    clear_flag();
    push("R7 second clear", 6'b000000, 6'b000110);

    tick(2);
    done = 1'b1;
    finish_run();
  end
endmodule